// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a simple host port and one 8-bit-wide EDO DRAM device. A single-beat request carrying an address, a direction and (for stores) a byte enters through a valid/ready handshake. The controller splits the address into row and column parts. It multiplexes them onto the shared DRAM address pins and sequences the active-low RAS#, CAS#, WE# and OE# strobes.

A row stays open after an access. A later request to the same row is served by another CAS# pulse alone. A request to another row first closes the page, waits out precharge and then activates the new row. Stores use early writes. Loads capture the DRAM output while CAS# is already back high, which relies on the EDO output hold. A free-running interval timer forces a CAS#-before-RAS# refresh. That refresh wins over waiting host traffic.

All DRAM timing minimums are given as clock-cycle parameters and enforced by a per-state down-counter.

Top module: `edo_page_ctrl`

## Requirements
- R1: After reset, RAS#, CAS#, WE# and OE# are high, the DQ driver enable is low, rd_valid is low and req_ready is high.
- R2: Before an activation, the row address (address bits above the COL_W column bits, zero-extended) is on dram_addr for at least one cycle, and it is unchanged in the cycle RAS# falls.
- R3: Before each access, the column address (the low COL_W address bits) is on dram_addr for at least one cycle, and it is unchanged in the cycle CAS# falls with RAS# low.
- R4: A request whose row equals the open row is served with a further CAS# pulse and no new RAS# activation.
- R5: A request to a different row raises RAS#, keeps it high at least T_RP cycles, then activates the new row. Every access returns the data last written to its full address.
- R6: A store is an early write: WE# is low at least one cycle before CAS# falls, the controller drives the byte, and OE# stays high while it drives.
- R7: Load data is sampled after CAS# has risen, while RAS# and OE# are low and WE# is high. It appears on rd_data together with a one-cycle rd_valid pulse.
- R8: Refresh is CAS#-before-RAS# with WE# high. Successive refreshes are at most REF_INT plus a short access-completion slack apart, even under continuous host traffic.
- R9: req_ready is low whenever CAS# is low, and during refresh and row changes.
- R10: CAS# stays low at least T_CAS cycles, stays high at least T_CP cycles, and RAS# stays low at least T_RAS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ROW_W+COL_W | {row, column} byte address |
| req_wdata | input | DQ_W | Store byte |
| rd_valid | output | 1 | One-cycle load-data strobe |
| rd_data | output | DQ_W | Load byte |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DQ_W | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DQ_W | Data from the DRAM |

## Verification
The assertions assume the host holds req_addr, req_we and req_wdata steady while req_valid is high. They also assume dram_dq_in carries the stored byte from a CAS# fall until RAS# or OE# rises, as an EDO part does. The bench drives the host port only at falling clock edges and keeps a request stable until the cycle it is accepted. Its DRAM model returns the stored byte only while RAS# and OE# are low. At all other times it returns a poison value, so any early or late sample shows up as a data mismatch.

// File: rtl/edo_pkg.sv
package edo_pkg;
    typedef enum logic [3:0] {
        S_IDLE,   // no row open
        S_ACT,    // row address on bus, RAS# falls at end
        S_RCD,    // RAS-to-CAS wait
        S_CSET,   // column on bus, CAS# falls at end
        S_CLO,    // CAS# low hold
        S_PAGE,   // CAS# precharge, row open
        S_CLOSE,  // wait minimum RAS# low, then raise it
        S_PRE,    // RAS# precharge
        S_RRAS,   // refresh: CAS# low, RAS# falls at end
        S_RHOLD   // refresh: RAS# low hold
    } ctl_st_e;
endpackage

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
    parameter int REF_INT = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic due
);
    localparam int TW = $clog2(REF_INT + 1);

    logic [TW-1:0] cnt_d, cnt_q;
    logic          due_d, due_q;

    always_comb begin
        cnt_d = cnt_q;
        due_d = due_q;
        if (ack) begin
            cnt_d = TW'(REF_INT - 1);
            due_d = 1'b0;
        end else if (cnt_q == '0) begin
            due_d = 1'b1;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= TW'(REF_INT - 1);
            due_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            due_q <= due_d;
        end
    end

    assign due = due_q;
endmodule

// File: rtl/edo_row_hit.sv
module edo_row_hit #(
    parameter int ROW_W = 11
) (
    input  logic [ROW_W-1:0] open_row,
    input  logic [ROW_W-1:0] new_row,
    output logic             hit
);
    assign hit = (open_row == new_row);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W   = 11,
    parameter int COL_W   = 10,
    parameter int DQ_W    = 8,
    parameter int CNT_W   = 4,
    parameter int T_RCD   = 2,
    parameter int T_CAS   = 2,
    parameter int T_CP    = 1,
    parameter int T_RAS   = 4,
    parameter int T_RP    = 3,
    parameter int REF_INT = 1560
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       req_valid,
    output logic                                       req_ready,
    input  logic                                       req_we,
    input  logic [ROW_W+COL_W-1:0]                     req_addr,
    input  logic [DQ_W-1:0]                            req_wdata,
    output logic                                       rd_valid,
    output logic [DQ_W-1:0]                            rd_data,
    output logic                                       dram_ras_n,
    output logic                                       dram_cas_n,
    output logic                                       dram_we_n,
    output logic                                       dram_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic [DQ_W-1:0]                            dram_dq_out,
    output logic                                       dram_dq_oe,
    input  logic [DQ_W-1:0]                            dram_dq_in
);
    localparam int DA_W = (ROW_W > COL_W) ? ROW_W : COL_W;

    typedef struct packed {
        ctl_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ras_age;
        logic             ras_n, cas_n, we_n, oe_n;
        logic [DA_W-1:0]  addr;
        logic [DQ_W-1:0]  dq_out;
        logic             dq_oe;
        logic [ROW_W-1:0] open_row;
        logic [ROW_W-1:0] req_row;
        logic [COL_W-1:0] req_col;
        logic             req_wr;
        logic [DQ_W-1:0]  wdata;
        logic             req_pend, ref_pend, rd_pend;
        logic [DQ_W-1:0]  rdat;
        logic             rvld;
    } ctl_t;

    ctl_t d, q;
    logic ref_due, ref_ack, row_hit;
    logic [ROW_W-1:0] in_row;
    logic [COL_W-1:0] in_col;

    assign in_row = req_addr[ROW_W+COL_W-1:COL_W];
    assign in_col = req_addr[COL_W-1:0];

    edo_ref_timer #(.REF_INT(REF_INT)) u_ref (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .due(ref_due)
    );

    edo_row_hit #(.ROW_W(ROW_W)) u_hit (
        .open_row(q.open_row), .new_row(in_row), .hit(row_hit)
    );

    assign req_ready = !ref_due &&
                       ((q.st == S_IDLE) || (q.st == S_PAGE && q.cnt == '0));

    always_comb begin
        d         = q;
        d.rvld    = 1'b0;
        ref_ack   = 1'b0;
        if (!q.ras_n) begin
            if (q.ras_age < CNT_W'(T_RAS)) d.ras_age = q.ras_age + 1'b1;
        end else begin
            d.ras_age = '0;
        end
        case (q.st)
            S_IDLE: begin
                if (ref_due) begin
                    ref_ack = 1'b1;
                    d.cas_n = 1'b0;
                    d.st    = S_RRAS;
                end else if (req_valid) begin
                    d.req_row = in_row;
                    d.req_col = in_col;
                    d.req_wr  = req_we;
                    d.wdata   = req_wdata;
                    d.addr    = DA_W'(in_row);
                    d.st      = S_ACT;
                end
            end
            S_ACT: begin
                d.ras_n    = 1'b0;
                d.open_row = q.req_row;
                d.cnt      = CNT_W'(T_RCD - 1);
                d.st       = S_RCD;
            end
            S_RCD: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.addr   = DA_W'(q.req_col);
                    d.we_n   = !q.req_wr;
                    d.oe_n   = q.req_wr;
                    d.dq_oe  = q.req_wr;
                    d.dq_out = q.wdata;
                    d.st     = S_CSET;
                end
            end
            S_CSET: begin
                d.cas_n = 1'b0;
                d.cnt   = CNT_W'(T_CAS - 1);
                d.st    = S_CLO;
            end
            S_CLO: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.cas_n   = 1'b1;
                    d.we_n    = 1'b1;
                    d.dq_oe   = 1'b0;
                    d.rd_pend = !q.req_wr;
                    d.cnt     = CNT_W'(T_CP - 1);
                    d.st      = S_PAGE;
                end
            end
            S_PAGE: begin
                if (q.rd_pend) begin
                    d.rdat    = dram_dq_in;
                    d.rvld    = 1'b1;
                    d.rd_pend = 1'b0;
                end
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (ref_due) begin
                    d.ref_pend = 1'b1;
                    d.st       = S_CLOSE;
                end else if (req_valid) begin
                    d.req_row = in_row;
                    d.req_col = in_col;
                    d.req_wr  = req_we;
                    d.wdata   = req_wdata;
                    if (row_hit) begin
                        d.addr   = DA_W'(in_col);
                        d.we_n   = !req_we;
                        d.oe_n   = req_we;
                        d.dq_oe  = req_we;
                        d.dq_out = req_wdata;
                        d.st     = S_CSET;
                    end else begin
                        d.req_pend = 1'b1;
                        d.st       = S_CLOSE;
                    end
                end
            end
            S_CLOSE: begin
                if (q.ras_age >= CNT_W'(T_RAS - 1)) begin
                    d.ras_n = 1'b1;
                    d.oe_n  = 1'b1;
                    d.cnt   = CNT_W'(T_RP - 1);
                    d.st    = S_PRE;
                end
            end
            S_PRE: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.ref_pend) begin
                    ref_ack    = 1'b1;
                    d.ref_pend = 1'b0;
                    d.cas_n    = 1'b0;
                    d.st       = S_RRAS;
                end else if (q.req_pend) begin
                    d.req_pend = 1'b0;
                    d.addr     = DA_W'(q.req_row);
                    d.st       = S_ACT;
                end else begin
                    d.st = S_IDLE;
                end
            end
            S_RRAS: begin
                d.ras_n = 1'b0;
                d.cnt   = CNT_W'(T_RAS - 1);
                d.st    = S_RHOLD;
            end
            S_RHOLD: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.ras_n = 1'b1;
                    d.cas_n = 1'b1;
                    d.cnt   = CNT_W'(T_RP - 1);
                    d.st    = S_PRE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.ras_n <= 1'b1;
            q.cas_n <= 1'b1;
            q.we_n  <= 1'b1;
            q.oe_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_valid    = q.rvld;
    assign rd_data     = q.rdat;
    assign dram_ras_n  = q.ras_n;
    assign dram_cas_n  = q.cas_n;
    assign dram_we_n   = q.we_n;
    assign dram_oe_n   = q.oe_n;
    assign dram_addr   = q.addr;
    assign dram_dq_out = q.dq_out;
    assign dram_dq_oe  = q.dq_oe;
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
    parameter int ROW_W = 11,
    parameter int COL_W = 10
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rd_valid,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_we_n,
    input logic dram_oe_n,
    input logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    input logic dram_dq_oe
);
    // R2
    row_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) && dram_cas_n |-> $stable(dram_addr));

    // R3
    col_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) && !dram_ras_n |-> $stable(dram_addr));

    // R6
    early_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) && !dram_we_n |-> !$past(dram_we_n) && dram_dq_oe);

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> dram_oe_n);

    // R8
    cbr_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) && !dram_cas_n |-> dram_we_n);

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !req_ready);

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R7
    rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !dram_ras_n || $past(!dram_ras_n));
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (.*);

// File: tb/edo_page_ctrl_tb.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb;
    localparam int ROW_W = 4, COL_W = 4, DQ_W = 8, CNT_W = 4;
    localparam int T_RCD = 2, T_CAS = 2, T_CP = 2, T_RAS = 4, T_RP = 2;
    localparam int REF_INT = 200, SLACK = 60;
    localparam int NLOC = 1 << (ROW_W + COL_W);
    localparam int DA_W = (ROW_W > COL_W) ? ROW_W : COL_W;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_we = 0;
    logic [ROW_W+COL_W-1:0] req_addr = '0;
    logic [DQ_W-1:0] req_wdata = '0;
    logic req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [DQ_W-1:0] rd_data, dq_out, dq_in, hold_q;
    logic [DA_W-1:0] addr;

    always #2 clk = ~clk;

    edo_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .CNT_W(CNT_W),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RAS(T_RAS), .T_RP(T_RP),
        .REF_INT(REF_INT)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(ras_n),
        .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr),
        .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

    int errors = 0, checks = 0, cyc = 0;
    int act_cnt = 0, ref_cnt = 0, last_ref = 0;
    int cas_lo = 0, cas_hi = 100, ras_lo = 0, ras_hi = 100;
    bit done = 0, live = 0;
    logic [DQ_W-1:0] dmem [NLOC];
    logic [DQ_W-1:0] emem [NLOC];
    logic [DQ_W-1:0] exp_q [$];
    logic [ROW_W-1:0] cur_row;
    logic p_ras = 1, p_cas = 1, p_we = 1;
    logic [DA_W-1:0] p_addr = '0;

    // EDO model: stored byte held while RAS# and OE# are low, poison otherwise
    assign dq_in = (!ras_n && !oe_n) ? hold_q : 8'hEE;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // DRAM pin model and per-clock checks, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (live) begin
            chk(!((!cas_n) && req_ready), "R9 ready while CAS low", req_ready, 0);
            if (p_ras && !ras_n) begin
                chk(ras_hi >= T_RP, "R5 RAS precharge", ras_hi, T_RP);
                if (cas_n) begin
                    act_cnt++;
                    chk(addr == p_addr, "R2 row setup", addr, p_addr);
                    cur_row = addr[ROW_W-1:0];
                end else begin
                    ref_cnt++;
                    chk(we_n, "R8 CBR WE high", we_n, 1);
                    chk(cyc - last_ref <= REF_INT + SLACK, "R8 refresh gap", cyc - last_ref, REF_INT + SLACK);
                    last_ref = cyc;
                end
            end
            if (!p_ras && ras_n) chk(ras_lo >= T_RAS, "R10 RAS low", ras_lo, T_RAS);
            if (p_cas && !cas_n) begin
                chk(cas_hi >= T_CP, "R10 CAS high", cas_hi, T_CP);
                if (!ras_n) begin
                    chk(addr == p_addr, "R3 col setup", addr, p_addr);
                    if (!we_n) begin
                        chk(!p_we && dq_oe && oe_n, "R6 early write", {p_we, dq_oe, oe_n}, 3'b011);
                        dmem[{cur_row, addr[COL_W-1:0]}] = dq_out;
                    end else begin
                        hold_q = dmem[{cur_row, addr[COL_W-1:0]}];
                    end
                end
            end
            if (!p_cas && cas_n) chk(cas_lo >= T_CAS, "R10 CAS low", cas_lo, T_CAS);
            if (rd_valid) begin
                if (exp_q.size() == 0) chk(0, "R7 unexpected rd_valid", 1, 0);
                else begin
                    logic [DQ_W-1:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R7 read data", rd_data, e);
                end
            end
            if (cyc - last_ref > REF_INT + SLACK) begin
                chk(0, "R8 refresh missing", cyc - last_ref, REF_INT + SLACK);
                last_ref = cyc;
            end
        end
        cas_lo = cas_n ? 0 : cas_lo + 1;
        cas_hi = cas_n ? cas_hi + 1 : 0;
        ras_lo = ras_n ? 0 : ras_lo + 1;
        ras_hi = ras_n ? ras_hi + 1 : 0;
        p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_addr = addr;
    end

    task automatic issue(input bit we, input int row, input int col, input logic [DQ_W-1:0] dat);
        int a;
        a = row * (1 << COL_W) + col;
        @(negedge clk);
        req_valid = 1; req_we = we; req_addr = a[ROW_W+COL_W-1:0]; req_wdata = dat;
        while (!req_ready) @(negedge clk);
        if (we) emem[a] = dat;
        else exp_q.push_back(emem[a]);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 500) begin @(negedge clk); n++; end
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R7 reads returned", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        int a0, r0, e;
        for (int i = 0; i < NLOC; i++) begin
            dmem[i] = 8'(i * 7 + 3);
            emem[i] = 8'(i * 7 + 3);
        end
        hold_q = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high", {ras_n, cas_n, we_n, oe_n}, 4'hF);
        chk(!dq_oe && !rd_valid, "R1 dq_oe/rd_valid low", {dq_oe, rd_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", req_ready, 1);
        live = 1; last_ref = cyc;

        // R4: reads within one row open it once
        a0 = act_cnt; r0 = ref_cnt;
        for (int c = 0; c < 4; c++) issue(0, 1, c, 0);
        drain();
        e = act_cnt - a0;
        chk(e >= 1 && e <= 1 + (ref_cnt - r0), "R4 one activation for page reads", e, 1);

        // R4/R6: stores then loads in the same row
        a0 = act_cnt; r0 = ref_cnt;
        for (int c = 4; c < 8; c++) issue(1, 1, c, 8'(8'hA0 + c));
        for (int c = 4; c < 8; c++) issue(0, 1, c, 0);
        drain();
        e = act_cnt - a0;
        chk(e <= ref_cnt - r0, "R4 no activation on row hits", e, 0);

        // R5: alternating rows
        a0 = act_cnt; r0 = ref_cnt;
        issue(1, 2, 0, 8'h3C);
        issue(0, 3, 5, 0);
        issue(0, 2, 0, 0);
        drain();
        e = act_cnt - a0;
        chk(e >= 3 && e <= 3 + (ref_cnt - r0), "R5 activation per row change", e, 3);

        // R8: idle period still refreshes
        r0 = ref_cnt;
        repeat (3 * REF_INT) @(negedge clk);
        chk(ref_cnt - r0 >= 2, "R8 refresh while idle", ref_cnt - r0, 2);

        // R8: continuous same-row traffic must not starve refresh
        r0 = ref_cnt;
        for (int k = 0; k < 120; k++) issue(k[0], 5, k % 16, 8'(k));
        drain();
        chk(ref_cnt - r0 >= 1, "R8 refresh under traffic", ref_cnt - r0, 1);

        // R5/R7: mixed random traffic
        for (int k = 0; k < 300; k++)
            issue($urandom_range(0, 1) == 1, $urandom_range(0, 15), $urandom_range(0, 15), 8'($urandom));
        drain();
        chk(1, "R5 random mix completed", 1, 1);
        summary();
    end
endmodule